// File: doc/BRIEF.md
# UART Host Data Register and Character Queues

This block is the host-side data path of a 16550-style serial port. A single register location serves two purposes: a read returns the oldest unread received character, and a write hands a character to the transmitter. When the divisor-access control input is high, the same location reaches an 8-bit low divisor byte instead, and neither character queue moves.

Received characters come from a deserializer as single-cycle strobes. Characters to send leave through a valid/ready handshake toward a serializer. Both directions hold characters in one of two modes, chosen by a queue-enable input. With the queues off, each direction has a single holding slot, and a newer character replaces an unread one. With the queues on, each direction has a first-in first-out queue of `FIFO_DEPTH` entries, and a character that arrives when the queue is full is dropped. The block also produces three flags: receive data ready, transmit holding empty, and a sticky receive overrun. A separate strobe tells the block that the host has read the line status, and that strobe clears the overrun flag.

Top module: `uart_data_port`

## Requirements
- R1: After reset, data_ready=0, thr_empty=1, overrun=0, tx_valid=0, div_lo=0x00 and host_rdata=0x00000000.
- R2: With dlab=0, host_rdata carries the oldest unread received character in bits [7:0] and zero in bits [31:8]. A read strobe consumes that character.
- R3: With dlab=1, a write stores host_wdata[7:0] into div_lo and a read returns div_lo in bits [7:0]. Neither access changes data_ready, thr_empty or the queued characters.
- R4: With fifo_en=0, a character that arrives while the previous one is unread replaces it and sets overrun.
- R5: With fifo_en=1, received characters are returned oldest first, up to FIFO_DEPTH of them. A character arriving while the queue is full is discarded, the stored ones are kept, and overrun is set.
- R6: With fifo_en=0, a data write clears thr_empty. A second write before the serializer takes the character replaces the pending character.
- R7: With fifo_en=1, the transmit queue accepts up to FIFO_DEPTH writes and delivers them oldest first. A write while it is full is discarded.
- R8: thr_empty returns to 1, and tx_valid to 0, in the cycle after the serializer takes the last pending character (tx_valid and tx_ready both high at a clock edge).
- R9: data_ready falls in the cycle after the read that consumes the last unread character.
- R10: overrun stays set until an lsr_rd strobe clears it. If a new overrun happens in the same cycle as the strobe, overrun stays set.
- R11: Any change of fifo_en empties both queues at the next edge. This leaves data_ready=0, thr_empty=1 and overrun=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding slot |
| dlab | input | 1 | 1 = data location accesses the low divisor byte |
| host_rd | input | 1 | Read strobe for the data location |
| host_wr | input | 1 | Write strobe for the data location |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 32 | Read data, bits [31:8] zero |
| lsr_rd | input | 1 | Host read the line status; clears overrun |
| rx_valid | input | 1 | Received character strobe from the deserializer |
| rx_data | input | 8 | Received character |
| tx_valid | output | 1 | A character is pending for the serializer |
| tx_data | output | 8 | Pending character |
| tx_ready | input | 1 | Serializer takes tx_data when tx_valid is high |
| data_ready | output | 1 | At least one unread received character |
| thr_empty | output | 1 | No character pending for transmission |
| overrun | output | 1 | Sticky receive overrun flag |
| div_lo | output | 8 | Low divisor byte |

## Verification
The hard cases are the overflow paths in both modes. Reaching them needs the receive side filled while the host does not read, or the transmit side filled while the serializer holds tx_ready low. The stimulus sweeps the number of characters pushed from zero to two past the queue depth, in each mode, from a fresh reset. For every count it computes arithmetically which characters survive and whether overrun is set, then drains and compares them in order. Separate sequences cover the cycle where an overrun and a status read coincide, and a mode change made while both queues hold data.

// File: rtl/uart_dp_pkg.sv
// Shared widths and character type for the UART data register path.
package uart_dp_pkg;
    localparam int CHAR_W = 8;
    localparam int REG_W  = 32;
    typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/uart_char_queue.sv
// Character queue with two personalities.
// deep=1: FIFO of DEPTH entries; a push while full (and no pop) is dropped.
// deep=0: one holding slot; a push while occupied (and no pop) overwrites it.
// lost pulses whenever a push was dropped or overwrote unread data.
// Assumes flush is a one-cycle request and has priority over push and pop.
module uart_char_queue #(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  deep,
    input  logic                  flush,
    input  logic                  push,
    input  uart_dp_pkg::char_t    push_data,
    input  logic                  pop,
    output uart_dp_pkg::char_t    head,
    output logic                  empty,
    output logic                  lost
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    uart_dp_pkg::char_t slots [DEPTH];
    logic [PTR_W-1:0]   rd_ptr, wr_ptr;
    logic [CNT_W-1:0]   count;
    logic               cap_full, do_pop, blocked, push_ok, wr_en;
    logic [PTR_W-1:0]   wr_addr;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy, acceptance and overflow decisions for this cycle.
    always_comb begin
        cap_full = deep ? (count == CNT_W'(DEPTH)) : (count != '0);
        do_pop   = pop && (count != '0) && !flush;
        blocked  = cap_full && !do_pop;
        push_ok  = push && !blocked && !flush;
        lost     = push && blocked && !flush;
        wr_en    = push_ok || (lost && !deep);
        wr_addr  = push_ok ? wr_ptr : rd_ptr;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            count <= count + CNT_W'(push_ok) - CNT_W'(do_pop);
        end
    end

    // One register per storage slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (wr_en && wr_addr == PTR_W'(g))
                slots[g] <= push_data;
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
endmodule

// File: rtl/uart_ovr_flag.sv
// Sticky overrun flag: set wins over clear, flush clears unconditionally.
// Assumes set and clr are single-cycle strobes.
module uart_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until a status read or a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) flag <= 1'b0;
        else if (set)        flag <= 1'b1;
        else if (clr)        flag <= 1'b0;
    end
endmodule

// File: rtl/uart_data_port.sv
// Host data location of a 16550-style UART: receive read, transmit write,
// low divisor byte when dlab is set, two queue modes and the status flags.
// Assumes host_rd / host_wr / lsr_rd are single-cycle strobes.
module uart_data_port #(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fifo_en,
    input  logic                            dlab,
    input  logic                            host_rd,
    input  logic                            host_wr,
    input  logic [uart_dp_pkg::CHAR_W-1:0]  host_wdata,
    output logic [uart_dp_pkg::REG_W-1:0]   host_rdata,
    input  logic                            lsr_rd,
    input  logic                            rx_valid,
    input  logic [uart_dp_pkg::CHAR_W-1:0]  rx_data,
    output logic                            tx_valid,
    output logic [uart_dp_pkg::CHAR_W-1:0]  tx_data,
    input  logic                            tx_ready,
    output logic                            data_ready,
    output logic                            thr_empty,
    output logic                            overrun,
    output logic [uart_dp_pkg::CHAR_W-1:0]  div_lo
);
    import uart_dp_pkg::*;
    localparam int PAD_W = REG_W - CHAR_W;

    logic  fifo_en_q, flush;
    logic  rx_pop, tx_push, tx_pop, rx_empty, tx_empty, rx_lost, tx_lost;
    char_t rx_head, tx_head;

    // Remember the previous mode so any change can trigger a flush.
    always_ff @(posedge clk) fifo_en_q <= fifo_en;

    // Low divisor byte, reached only while dlab is set.
    always_ff @(posedge clk) begin
        if (!rst_n)                div_lo <= '0;
        else if (dlab && host_wr)  div_lo <= host_wdata;
    end

    assign flush   = rst_n && (fifo_en != fifo_en_q);
    assign rx_pop  = host_rd && !dlab;
    assign tx_push = host_wr && !dlab;
    assign tx_pop  = tx_valid && tx_ready;

    uart_char_queue #(.DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .deep(fifo_en), .flush(flush),
        .push(rx_valid), .push_data(rx_data), .pop(rx_pop),
        .head(rx_head), .empty(rx_empty), .lost(rx_lost)
    );

    uart_char_queue #(.DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .deep(fifo_en), .flush(flush),
        .push(tx_push), .push_data(host_wdata), .pop(tx_pop),
        .head(tx_head), .empty(tx_empty), .lost(tx_lost)
    );

    uart_ovr_flag u_ovr (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .set(rx_lost), .clr(lsr_rd), .flag(overrun)
    );

    assign host_rdata = {{PAD_W{1'b0}}, (dlab ? div_lo : rx_head)};
    assign tx_valid   = !tx_empty;
    assign tx_data    = tx_head;
    assign data_ready = !rx_empty;
    assign thr_empty  = tx_empty;
endmodule

// File: rtl/uart_data_port_chk.sv
// Temporal checks for uart_data_port, attached by bind below.
module uart_data_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_en,
    input logic       dlab,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic       lsr_rd,
    input logic       rx_valid,
    input logic       data_ready,
    input logic       thr_empty,
    input logic       overrun,
    input logic [7:0] div_lo,
    input logic       flush
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (thr_empty && !data_ready && !overrun && div_lo == 8'h00));

    a_r3_divisor_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dlab && host_wr) |=> (div_lo == $past(host_wdata)));

    a_r4_single_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !flush && data_ready && rx_valid && !(host_rd && !dlab))
        |=> (overrun && data_ready));

    a_r6_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !dlab && !flush) |=> !thr_empty);

    a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_empty && !(host_wr && !dlab)) |=> thr_empty);

    a_r9_last_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !flush && data_ready && host_rd && !dlab && !rx_valid)
        |=> !data_ready);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_rd && !flush) |=> overrun);

    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (thr_empty && !data_ready && !overrun));
endmodule

bind uart_data_port uart_data_port_chk i_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dlab(dlab),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .lsr_rd(lsr_rd), .rx_valid(rx_valid), .data_ready(data_ready),
    .thr_empty(thr_empty), .overrun(overrun), .div_lo(div_lo), .flush(flush)
);

// File: tb/test_uart_data_port.sv
module test_uart_data_port;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0, dlab = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_wdata = '0, rx_data = '0;
    logic        lsr_rd = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0;
    logic [31:0] host_rdata;
    logic        tx_valid, data_ready, thr_empty, overrun;
    logic [7:0]  tx_data, div_lo;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_data_port #(.FIFO_DEPTH(D)) i_uart_data_port (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dlab(dlab),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .lsr_rd(lsr_rd), .rx_valid(rx_valid),
        .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .data_ready(data_ready), .thr_empty(thr_empty),
        .overrun(overrun), .div_lo(div_lo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic mode);
        fifo_en = mode; dlab = 0; host_rd = 0; host_wr = 0; lsr_rd = 0;
        rx_valid = 0; tx_ready = 0;
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic rx_char(input logic [7:0] c);
        rx_valid = 1; rx_data = c;
        step();
        rx_valid = 0;
    endtask

    task automatic host_write(input logic [7:0] c);
        host_wr = 1; host_wdata = c;
        step();
        host_wr = 0;
    endtask

    task automatic host_read(output logic [31:0] v);
        host_rd = 1;
        #1 v = host_rdata;
        step();
        host_rd = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int exp_n;

        // R1: reset state
        do_reset(1'b0);
        check("R1 data_ready", 32'(data_ready), 32'd0);
        check("R1 thr_empty", 32'(thr_empty), 32'd1);
        check("R1 overrun", 32'(overrun), 32'd0);
        check("R1 tx_valid", 32'(tx_valid), 32'd0);
        check("R1 div_lo", 32'(div_lo), 32'd0);
        check("R1 host_rdata", host_rdata, 32'd0);

        // Receive sweep: R2 R4 R5 R9 R10
        for (int mode = 0; mode < 2; mode++) begin
            for (int k = 0; k <= D + 2; k++) begin
                do_reset(mode[0]);
                for (int i = 0; i < k; i++) rx_char(8'hA0 + 8'(i));
                exp_n = (mode == 1) ? ((k < D) ? k : D) : ((k > 0) ? 1 : 0);
                check("R9 data_ready after fill", 32'(data_ready), 32'(k > 0));
                check(mode == 1 ? "R5 overrun" : "R4 overrun", 32'(overrun),
                      32'((mode == 1) ? (k > D) : (k > 1)));
                for (int j = 0; j < exp_n; j++) begin
                    host_read(v);
                    check(mode == 1 ? "R5 order R2" : "R4 newest R2", v,
                          32'((mode == 1) ? (8'hA0 + 8'(j)) : (8'hA0 + 8'(k - 1))));
                end
                check("R9 data_ready after drain", 32'(data_ready), 32'd0);
                if (overrun) begin
                    check("R10 sticky", 32'(overrun), 32'd1);
                    lsr_rd = 1; step(); lsr_rd = 0;
                    check("R10 cleared", 32'(overrun), 32'd0);
                end
            end
        end

        // Transmit sweep: R6 R7 R8
        for (int mode = 0; mode < 2; mode++) begin
            for (int k = 0; k <= D + 2; k++) begin
                do_reset(mode[0]);
                for (int i = 0; i < k; i++) host_write(8'h30 + 8'(i));
                exp_n = (mode == 1) ? ((k < D) ? k : D) : ((k > 0) ? 1 : 0);
                check("R6 thr_empty after writes", 32'(thr_empty), 32'(k == 0));
                tx_ready = 1;
                for (int j = 0; j < exp_n; j++) begin
                    check("R7 tx_valid", 32'(tx_valid), 32'd1);
                    check(mode == 1 ? "R7 order" : "R6 newest", 32'(tx_data),
                          32'((mode == 1) ? (8'h30 + 8'(j)) : (8'h30 + 8'(k - 1))));
                    step();
                end
                tx_ready = 0;
                check("R8 thr_empty after drain", 32'(thr_empty), 32'd1);
                check("R8 tx_valid after drain", 32'(tx_valid), 32'd0);
            end
        end

        // R3: divisor byte access leaves queues alone
        do_reset(1'b1);
        rx_char(8'h77);
        dlab = 1;
        host_write(8'h5A);
        check("R3 div_lo", 32'(div_lo), 32'h5A);
        check("R3 thr_empty untouched", 32'(thr_empty), 32'd1);
        host_read(v);
        check("R3 read divisor", v, 32'h5A);
        check("R3 data_ready untouched", 32'(data_ready), 32'd1);
        dlab = 0;
        host_read(v);
        check("R3 rx char preserved", v, 32'h77);

        // R10: overrun and status read in the same cycle keep the flag
        do_reset(1'b0);
        rx_char(8'h11);
        rx_valid = 1; rx_data = 8'h22; lsr_rd = 1;
        step();
        rx_valid = 0; lsr_rd = 0;
        check("R10 set wins", 32'(overrun), 32'd1);
        lsr_rd = 1; step(); lsr_rd = 0;
        check("R10 clear", 32'(overrun), 32'd0);

        // R11: mode change flushes everything
        do_reset(1'b1);
        for (int i = 0; i < D + 1; i++) rx_char(8'h50 + 8'(i));
        host_write(8'h61);
        host_write(8'h62);
        check("R11 precondition overrun", 32'(overrun), 32'd1);
        fifo_en = 0;
        step();
        check("R11 data_ready", 32'(data_ready), 32'd0);
        check("R11 thr_empty", 32'(thr_empty), 32'd1);
        check("R11 overrun", 32'(overrun), 32'd0);
        check("R11 tx_valid", 32'(tx_valid), 32'd0);
        rx_char(8'h99);
        host_read(v);
        check("R11 single mode after flush", v, 32'h99);

        finish_run();
    end
endmodule